// File: doc/BRIEF.md
# UART Extended Register Bank Decoder

This block sits between a host bus and a 16550-style UART core. The host presents a 3-bit register offset with read and write strobes. The block decides which register each access reaches: a normal register, a divisor latch byte, or a register in a hidden extended bank. The extended bank holds a flow-feature register and four software flow-control characters. The decoder keeps the extended bank and drives its contents, and the normal control registers, to the rest of the UART as plain outputs.

Bank selection follows from the stored line control value. When that value equals one special key, the extended bank replaces the normal registers at offsets 2 and 4 to 7. Any other value restores the normal map, and the extended contents are kept. Software can therefore probe for the extended bank by reading offset 2 before and after writing the key. The FIFOs, the serial engine and interrupt priority logic are outside this block. Their status values come in on input ports, and the remaining normal registers are plain storage. Read data is registered.

Top module: `uart_xreg_decoder`

## Requirements
- R1: After synchronous reset: the line control value is 0x00 and the normal bank is selected. The flow-feature register, all four flow characters, every normal storage register and `rdata_o` are 0x00.
- R2: A write of 0xBF to offset 3 selects the extended bank from the next cycle (`enh_mode_o`=1). A write of any other value to offset 3 selects the normal bank, and this includes 0xBE.
- R3: In the extended bank, offset 2 reads and writes the flow-feature register. Its field outputs are: bit 7 = `auto_cts_o`, bit 6 = `auto_rts_o`, bit 5 = `spec_det_o`, bit 4 = `enh_func_o`, bits 3:2 = `tx_flow_sel_o`, bits 1:0 = `rx_flow_sel_o`.
- R4: In the extended bank, offsets 4, 5, 6 and 7 read and write XON1, XON2, XOFF1 and XOFF2, in that order.
- R5: In the normal bank, a read at offset 2 returns `iir_i`. A write at offset 2 loads `fcr_o` and leaves the flow-feature register unchanged.
- R6: In the normal bank, offset 4 is modem control storage and offset 7 is scratch storage. Offset 5 reads `lsr_i` and offset 6 reads `msr_i`, and writes to offsets 5 and 6 are ignored. Normal-bank writes at offsets 4 to 7 leave the flow characters unchanged.
- R7: When line control bit 7 is 1, offsets 0 and 1 reach the divisor low and high bytes. This also holds in the extended bank, because 0xBF has bit 7 set. When bit 7 is 0, offset 0 reads `rx_data_i` and writes `thr_o`, and offset 1 is the interrupt enable register.
- R8: Offset 3 reads back the last value written to line control, in every bank.
- R9: The extended registers keep their contents while the normal bank is selected, and show them again when the bank is re-entered.
- R10: `rdata_o` updates one cycle after a clock edge with `rd_i`=1. It shows the state from before any write in that same cycle, and it holds its value while `rd_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rx_data_i | input | 8 | Receive holding byte from the FIFO |
| iir_i | input | 8 | Interrupt identification value |
| lsr_i | input | 8 | Line status value |
| msr_i | input | 8 | Modem status value |
| rdata_o | output | 8 | Registered read data |
| enh_mode_o | output | 1 | Extended bank selected |
| lcr_o | output | 8 | Line control value |
| div_lo_o | output | 8 | Divisor low byte |
| div_hi_o | output | 8 | Divisor high byte |
| ier_o | output | 8 | Interrupt enable |
| fcr_o | output | 8 | FIFO control |
| mcr_o | output | 8 | Modem control |
| thr_o | output | 8 | Last transmit byte written |
| auto_cts_o | output | 1 | Automatic CTS stop enable |
| auto_rts_o | output | 1 | Automatic RTS drop enable |
| spec_det_o | output | 1 | Special character detect enable |
| enh_func_o | output | 1 | Enhanced function enable |
| tx_flow_sel_o | output | 2 | Transmit XON/XOFF select |
| rx_flow_sel_o | output | 2 | Receive XON/XOFF select |
| xon1_o | output | 8 | XON character 1 |
| xon2_o | output | 8 | XON character 2 |
| xoff1_o | output | 8 | XOFF character 1 |
| xoff2_o | output | 8 | XOFF character 2 |

## Verification
A read and a write can fall in the same cycle, and the write can be the one that switches banks. The bench provokes this by asserting both strobes on the key write to offset 3. It also writes the flow-feature register while reading it. In each case the returned byte must be the value from before the edge: the old line control value, or the old feature value. The outputs that change must show the new bank or field values one cycle later.

// File: rtl/uxr_pkg.sv
package uxr_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [3:0] {
    T_RXTX, T_DLL, T_IER, T_DLM, T_IIR_FCR, T_EFR, T_LCR,
    T_MCR, T_LSR, T_MSR, T_SCR, T_XCHAR
  } target_e;

  typedef struct packed {
    logic       auto_cts;
    logic       auto_rts;
    logic       spec_det;
    logic       enh_func;
    logic [1:0] tx_sel;
    logic [1:0] rx_sel;
  } feat_t;

  function automatic target_e decode(input logic [AW-1:0] a, input logic enh, input logic dlab);
    target_e t;
    case (a)
      3'd0: t = dlab ? T_DLL : T_RXTX;
      3'd1: t = dlab ? T_DLM : T_IER;
      3'd2: t = enh ? T_EFR : T_IIR_FCR;
      3'd3: t = T_LCR;
      3'd4: t = enh ? T_XCHAR : T_MCR;
      3'd5: t = enh ? T_XCHAR : T_LSR;
      3'd6: t = enh ? T_XCHAR : T_MSR;
      default: t = enh ? T_XCHAR : T_SCR;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/uxr_bank_sel.sv
module uxr_bank_sel
  import uxr_pkg::*;
#(
  parameter logic [DW-1:0] ENH_KEY = 8'hBF
) (
  input  logic [DW-1:0] lcr_q,
  input  logic [AW-1:0] addr,
  output logic          enh_mode,
  output target_e       tgt,
  output logic [1:0]    xidx
);
  localparam int DLAB_BIT = DW - 1;

  always_comb begin
    enh_mode = (lcr_q == ENH_KEY);
    tgt      = decode(addr, enh_mode, lcr_q[DLAB_BIT]);
    xidx     = addr[1:0];
  end
endmodule

// File: rtl/uxr_std_regs.sv
module uxr_std_regs
  import uxr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  target_e       tgt,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lcr_q,
  output logic [DW-1:0] dll_q,
  output logic [DW-1:0] dlm_q,
  output logic [DW-1:0] ier_q,
  output logic [DW-1:0] fcr_q,
  output logic [DW-1:0] mcr_q,
  output logic [DW-1:0] scr_q,
  output logic [DW-1:0] thr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q <= '0; dll_q <= '0; dlm_q <= '0; ier_q <= '0;
      fcr_q <= '0; mcr_q <= '0; scr_q <= '0; thr_q <= '0;
    end else if (we) begin
      case (tgt)
        T_LCR:     lcr_q <= wdata;
        T_DLL:     dll_q <= wdata;
        T_DLM:     dlm_q <= wdata;
        T_IER:     ier_q <= wdata;
        T_IIR_FCR: fcr_q <= wdata;
        T_MCR:     mcr_q <= wdata;
        T_SCR:     scr_q <= wdata;
        T_RXTX:    thr_q <= wdata;
        default: ;
      endcase
    end
  end

  // R8: line control keeps the written byte
  a_r8_lcr_written: assert property (@(posedge clk) disable iff (rst)
    (we && tgt == T_LCR) |=> (lcr_q == $past(wdata)));
  // R7: divisor low byte loads through its offset
  a_r7_div_lo_load: assert property (@(posedge clk) disable iff (rst)
    (we && tgt == T_DLL) |=> (dll_q == $past(wdata)));
  // R5: FIFO control loads only on its own target
  a_r5_fcr_hold: assert property (@(posedge clk) disable iff (rst)
    !(we && tgt == T_IIR_FCR) |=> $stable(fcr_q));
endmodule

// File: rtl/uxr_enh_regs.sv
module uxr_enh_regs
  import uxr_pkg::*;
#(
  parameter int NUM_XCHAR = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  target_e       tgt,
  input  logic [1:0]    xidx,
  input  logic [DW-1:0] wdata,
  output feat_t         efr_q,
  output logic [DW-1:0] xchar_q [NUM_XCHAR]
);
  logic [NUM_XCHAR-1:0] xwe;

  always_ff @(posedge clk) begin
    if (rst) efr_q <= '0;
    else if (we && tgt == T_EFR) efr_q <= feat_t'(wdata);
  end

  for (genvar g = 0; g < NUM_XCHAR; g++) begin : g_xchar
    assign xwe[g] = we && (tgt == T_XCHAR) && (xidx == g[1:0]);
    always_ff @(posedge clk) begin
      if (rst) xchar_q[g] <= '0;
      else if (xwe[g]) xchar_q[g] <= wdata;
    end
  end

  // R3: feature register takes write data
  a_r3_efr_load: assert property (@(posedge clk) disable iff (rst)
    (we && tgt == T_EFR) |=> (efr_q == $past(wdata)));
  // R9: feature register retained without a write to it
  a_r9_efr_retain: assert property (@(posedge clk) disable iff (rst)
    !(we && tgt == T_EFR) |=> $stable(efr_q));
  // R4: at most one flow character written per cycle
  a_r4_xchar_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(xwe));
  // R6: no flow character changes outside the extended bank
  a_r6_xchar_untouched: assert property (@(posedge clk) disable iff (rst)
    (tgt != T_XCHAR) |=> $stable(xchar_q[0]) && $stable(xchar_q[NUM_XCHAR-1]));
endmodule

// File: rtl/uxr_read_mux.sv
module uxr_read_mux
  import uxr_pkg::*;
#(
  parameter int NUM_XCHAR = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  target_e       tgt,
  input  logic [1:0]    xidx,
  input  logic [DW-1:0] rx_data,
  input  logic [DW-1:0] iir,
  input  logic [DW-1:0] lsr,
  input  logic [DW-1:0] msr,
  input  logic [DW-1:0] lcr_q,
  input  logic [DW-1:0] dll_q,
  input  logic [DW-1:0] dlm_q,
  input  logic [DW-1:0] ier_q,
  input  logic [DW-1:0] mcr_q,
  input  logic [DW-1:0] scr_q,
  input  feat_t         efr_q,
  input  logic [DW-1:0] xchar_q [NUM_XCHAR],
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_next;

  always_comb begin
    case (tgt)
      T_RXTX:    rd_next = rx_data;
      T_DLL:     rd_next = dll_q;
      T_IER:     rd_next = ier_q;
      T_DLM:     rd_next = dlm_q;
      T_IIR_FCR: rd_next = iir;
      T_EFR:     rd_next = efr_q;
      T_LCR:     rd_next = lcr_q;
      T_MCR:     rd_next = mcr_q;
      T_LSR:     rd_next = lsr;
      T_MSR:     rd_next = msr;
      T_SCR:     rd_next = scr_q;
      T_XCHAR:   rd_next = xchar_q[xidx];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= rd_next;
  end

  // R10: read data holds when not reading
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));
  // R6: line status passes through on a read
  a_r6_lsr_read: assert property (@(posedge clk) disable iff (rst)
    (re && tgt == T_LSR) |=> (rdata == $past(lsr)));
endmodule

// File: rtl/uart_xreg_decoder.sv
module uart_xreg_decoder
  import uxr_pkg::*;
#(
  parameter logic [7:0] ENH_KEY   = 8'hBF,
  parameter int         NUM_XCHAR = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] rx_data_i,
  input  logic [7:0] iir_i,
  input  logic [7:0] lsr_i,
  input  logic [7:0] msr_i,
  output logic [7:0] rdata_o,
  output logic       enh_mode_o,
  output logic [7:0] lcr_o,
  output logic [7:0] div_lo_o,
  output logic [7:0] div_hi_o,
  output logic [7:0] ier_o,
  output logic [7:0] fcr_o,
  output logic [7:0] mcr_o,
  output logic [7:0] thr_o,
  output logic       auto_cts_o,
  output logic       auto_rts_o,
  output logic       spec_det_o,
  output logic       enh_func_o,
  output logic [1:0] tx_flow_sel_o,
  output logic [1:0] rx_flow_sel_o,
  output logic [7:0] xon1_o,
  output logic [7:0] xon2_o,
  output logic [7:0] xoff1_o,
  output logic [7:0] xoff2_o
);
  target_e       tgt;
  logic [1:0]    xidx;
  logic [DW-1:0] lcr_q, scr_q;
  feat_t         efr_q;
  logic [DW-1:0] xchar_q [NUM_XCHAR];

  uxr_bank_sel #(.ENH_KEY(ENH_KEY)) u_sel (
    .lcr_q(lcr_q), .addr(addr_i), .enh_mode(enh_mode_o), .tgt(tgt), .xidx(xidx)
  );

  uxr_std_regs u_std (
    .clk(clk), .rst(rst), .we(wr_i), .tgt(tgt), .wdata(wdata_i),
    .lcr_q(lcr_q), .dll_q(div_lo_o), .dlm_q(div_hi_o), .ier_q(ier_o),
    .fcr_q(fcr_o), .mcr_q(mcr_o), .scr_q(scr_q), .thr_q(thr_o)
  );

  uxr_enh_regs #(.NUM_XCHAR(NUM_XCHAR)) u_enh (
    .clk(clk), .rst(rst), .we(wr_i), .tgt(tgt), .xidx(xidx), .wdata(wdata_i),
    .efr_q(efr_q), .xchar_q(xchar_q)
  );

  uxr_read_mux #(.NUM_XCHAR(NUM_XCHAR)) u_rd (
    .clk(clk), .rst(rst), .re(rd_i), .tgt(tgt), .xidx(xidx),
    .rx_data(rx_data_i), .iir(iir_i), .lsr(lsr_i), .msr(msr_i),
    .lcr_q(lcr_q), .dll_q(div_lo_o), .dlm_q(div_hi_o), .ier_q(ier_o),
    .mcr_q(mcr_o), .scr_q(scr_q), .efr_q(efr_q), .xchar_q(xchar_q),
    .rdata(rdata_o)
  );

  assign lcr_o         = lcr_q;
  assign auto_cts_o    = efr_q.auto_cts;
  assign auto_rts_o    = efr_q.auto_rts;
  assign spec_det_o    = efr_q.spec_det;
  assign enh_func_o    = efr_q.enh_func;
  assign tx_flow_sel_o = efr_q.tx_sel;
  assign rx_flow_sel_o = efr_q.rx_sel;
  assign xon1_o        = xchar_q[0];
  assign xon2_o        = xchar_q[1];
  assign xoff1_o       = xchar_q[2];
  assign xoff2_o       = xchar_q[NUM_XCHAR-1];

  // R2: key write enters the extended bank
  a_r2_key_enters: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == 3'd3 && wdata_i == ENH_KEY) |=> enh_mode_o);
  // R2: any other line control write leaves it
  a_r2_other_leaves: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == 3'd3 && wdata_i != ENH_KEY) |=> !enh_mode_o);
endmodule

// File: tb/test_uart_xreg_decoder.sv
module test_uart_xreg_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rx_data_i = 8'h5A, iir_i = 8'hC1, lsr_i = 8'h60, msr_i = 8'hB0;
  logic [7:0] rdata_o, lcr_o, div_lo_o, div_hi_o, ier_o, fcr_o, mcr_o, thr_o;
  logic       enh_mode_o, auto_cts_o, auto_rts_o, spec_det_o, enh_func_o;
  logic [1:0] tx_flow_sel_o, rx_flow_sel_o;
  logic [7:0] xon1_o, xon2_o, xoff1_o, xoff2_o;

  int tests = 0, fails = 0;

  uart_xreg_decoder i_uart_xreg_decoder (.*);

  always #10 clk = ~clk;

  // entry: {wr, rd, chk, req[3:0], addr[2:0], wdata[7:0], exp[7:0]}
  function automatic logic [25:0] v(bit w, bit r, bit c, int q, int a, int d, int e);
    return {w, r, c, 4'(q), 3'(a), 8'(d), 8'(e)};
  endfunction

  localparam int NV = 44;
  localparam logic [25:0] VEC [NV] = '{
    v(1,0,0,2,3,8'h03,0),      // normal bank, DLAB clear
    v(0,1,1,5,2,0,8'hC1),      // R5 offset 2 reads iir
    v(1,0,0,5,2,8'h87,0),      // FCR write
    v(0,1,1,8,3,0,8'h03),      // R8 line control readback
    v(1,0,0,6,7,8'h3C,0),
    v(0,1,1,6,7,0,8'h3C),      // R6 scratch
    v(1,0,0,6,5,8'hFF,0),
    v(0,1,1,6,5,0,8'h60),      // R6 LSR write ignored
    v(0,1,1,6,6,0,8'hB0),      // R6 MSR read
    v(1,0,0,6,4,8'h0B,0),
    v(0,1,1,6,4,0,8'h0B),      // R6 MCR
    v(0,1,1,7,0,0,8'h5A),      // R7 rx data
    v(1,0,0,7,1,8'h0F,0),
    v(0,1,1,7,1,0,8'h0F),      // R7 IER
    v(1,0,0,7,3,8'h83,0),      // DLAB set
    v(1,0,0,7,0,8'h0C,0),
    v(1,0,0,7,1,8'h00,0),
    v(0,1,1,7,0,0,8'h0C),      // R7 divisor low
    v(0,1,1,7,1,0,8'h00),      // R7 divisor high
    v(1,0,0,2,3,8'hBF,0),      // enter extended bank
    v(0,1,1,3,2,0,8'h00),      // R3 feature reset value
    v(1,0,0,3,2,8'hC0,0),
    v(0,1,1,3,2,0,8'hC0),      // R3 feature readback
    v(1,0,0,4,4,8'h11,0),
    v(1,0,0,4,5,8'h12,0),
    v(1,0,0,4,6,8'h13,0),
    v(1,0,0,4,7,8'h93,0),
    v(0,1,1,4,4,0,8'h11),      // R4 XON1
    v(0,1,1,4,5,0,8'h12),      // R4 XON2
    v(0,1,1,4,6,0,8'h13),      // R4 XOFF1
    v(0,1,1,4,7,0,8'h93),      // R4 XOFF2
    v(0,1,1,8,3,0,8'hBF),      // R8 in extended bank
    v(0,1,1,7,0,0,8'h0C),      // R7 divisor in extended bank
    v(1,0,0,2,3,8'h03,0),      // leave
    v(0,1,1,2,2,0,8'hC1),      // R2 back to iir
    v(0,1,1,2,4,0,8'h0B),      // R2 MCR visible again
    v(0,1,1,2,7,0,8'h3C),      // R2 scratch visible again
    v(1,0,0,6,4,8'h01,0),      // MCR, not XON1
    v(1,0,0,5,2,8'h07,0),      // FCR, not feature
    v(1,0,0,9,3,8'hBF,0),      // re-enter
    v(0,1,1,9,2,0,8'hC0),      // R9 feature retained
    v(0,1,1,9,4,0,8'h11),      // R9 XON1 retained
    v(1,0,0,2,3,8'hBE,0),      // near-key value
    v(0,1,1,2,2,0,8'hC1)       // R2 0xBE selects normal bank
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit w, input bit r, input int a, input int d);
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = 3'(a); wdata_i = 8'(d);
    @(negedge clk);
    wr_i = 0; rd_i = 0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 rdata", rdata_o, 0);
    check("R1 mode", enh_mode_o, 0);
    check("R1 lcr", lcr_o, 0);
    check("R1 xoff2", xoff2_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      e = VEC[i];
      op(e[25], e[24], int'(e[18:16]), int'(e[15:8]));
      if (e[23]) begin
        tests++;
        if (rdata_o !== e[7:0]) begin
          fails++;
          $display("FAIL R%0d vec %0d actual=%0h expected=%0h", e[22:19], i, rdata_o, e[7:0]);
        end
      end
    end

    check("R5 fcr_o", fcr_o, 8'h07);
    check("R3 auto_cts", auto_cts_o, 1);
    check("R3 auto_rts", auto_rts_o, 1);
    check("R4 xon1_o", xon1_o, 8'h11);
    check("R4 xoff2_o", xoff2_o, 8'h93);
    check("R2 mode after BE", enh_mode_o, 0);

    // R10 same-cycle key write and read
    op(1, 1, 3, 8'hBF);
    check("R10 old lcr", rdata_o, 8'hBE);
    check("R2 mode after key", enh_mode_o, 1);
    op(1, 1, 2, 8'h35);
    check("R10 old feature", rdata_o, 8'hC0);
    check("R3 auto_cts", auto_cts_o, 0);
    check("R3 spec_det", spec_det_o, 1);
    check("R3 enh_func", enh_func_o, 1);
    check("R3 tx_sel", tx_flow_sel_o, 1);
    check("R3 rx_sel", rx_flow_sel_o, 1);
    op(0, 0, 2, 0);
    check("R10 hold", rdata_o, 8'hC0);

    // R1 reset mid-run
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    check("R1 xon1", xon1_o, 0);
    check("R1 enh_func", enh_func_o, 0);
    check("R1 mode", enh_mode_o, 0);
    check("R1 rdata", rdata_o, 0);
    check("R1 mcr", mcr_o, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule